// File: doc/BRIEF.md
# Bit-Serial All-Ones Alarm Detector

This block watches a received T1 or E1 bit stream, one bit per enabled clock, and decides whether the far end is sending the all-ones alarm indication signal. It cuts the stream into back-to-back windows of fixed length and counts the binary zeros in each one. A window is "quiet" when it holds no more zeros than a small threshold. The alarm is raised or dropped only when a window closes. The one exception is a frame-recovery event in one E1 rule, which drops the alarm at once.

Three rules share the same counters. Each rule has its own window length, window count and frame-loss qualifier. The T1 rule works on double frames. The first E1 rule needs one long window plus loss of frame alignment. The second E1 rule looks at pairs of long windows and ignores frame loss. The frame aligner is a separate block: this block only consumes its loss-of-frame and frame-found flags.

Top module: `ais_detector`

## Requirements
- R1: While `rst_n` is low, `ais` is 0. After reset, the first window begins with the first bit accepted by `bit_en`, and every window follows the previous one with no gap.
- R2: On a cycle with `bit_en` low, the bit is not counted, the window position does not move, and `ais` does not change (apart from the R8 clear).
- R3: With `std_sel`=0 (T1), `ais` becomes 1 at the end of a window of `T1_WIN` bits when that window and the window just before it are both quiet and `lof` is 1 on the last bit.
- R4: With `std_sel`=0, a quiet window never sets `ais` when `lof` is 0 on its last bit.
- R5: With `std_sel`=1 and `e1_rule`=0, `ais` becomes 1 at the end of any quiet window of `E1_WIN` bits whose last bit arrives with `lof`=1. No earlier window is needed.
- R6: With `std_sel`=1 and `e1_rule`=1, `ais` becomes 1 at the end of the second of two consecutive quiet `E1_WIN`-bit windows, whatever the value of `lof`.
- R7: With `std_sel`=1 and `e1_rule`=1, `ais` clears at the end of the second of two consecutive non-quiet windows. A single non-quiet window leaves `ais` set.
- R8: With `std_sel`=1 and `e1_rule`=1, `frame_found`=1 on any cycle makes `ais` 0 on the next cycle. This holds even if `bit_en` is low, and it overrides a set decision from a window that closes in the same cycle.
- R9: With `e1_rule`=0 or `std_sel`=0, `ais` clears at the end of any non-quiet window.
- R10: Outside R8, `ais` changes only in the cycle after the last bit of a window is accepted.
- R11: A window is quiet when it holds at most `ZERO_LIMIT` zeros (default 2). Exactly `ZERO_LIMIT` zeros is quiet. `ZERO_LIMIT`+1 or more zeros is not quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Received data bit |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| lof | input | 1 | Loss of frame alignment from the aligner |
| frame_found | input | 1 | Frame alignment signal found, used by the paired E1 rule |
| std_sel | input | 1 | 0 selects T1 windows, 1 selects E1 windows |
| e1_rule | input | 1 | E1 only: 0 = single window gated by frame loss, 1 = window pairs |
| ais | output | 1 | Alarm indication signal detected |

## Verification
The bench builds the block with `T1_WIN`=12 and `E1_WIN`=16, and keeps `ZERO_LIMIT` at 2. Short windows let thousands of window closings occur in one short run. They also bring the exact-threshold counts, back-to-back windows, long `bit_en` stalls and a `frame_found` pulse landing on a closing bit within reach of both directed and random stimulus. Because the zero threshold is the real one, a 7 % zero rate in random data lands windows on both sides of it often.

// File: rtl/ais_pkg.sv
package ais_pkg;

    typedef enum logic [1:0] {
        RULE_T1        = 2'd0,
        RULE_E1_SINGLE = 2'd1,
        RULE_E1_PAIR   = 2'd2
    } ais_rule_e;

    typedef struct packed {
        logic ais;
        logic prev_quiet;
        logic prev_noisy;
    } rule_state_t;

endpackage

// File: rtl/ais_win_ctr.sv
module ais_win_ctr #(
    parameter int T1_WIN = 386,
    parameter int E1_WIN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic e1_sel,
    output logic win_end
);
    localparam int MAX_WIN = (T1_WIN > E1_WIN) ? T1_WIN : E1_WIN;
    localparam int CW      = $clog2(MAX_WIN + 1);

    logic [CW-1:0] pos_d, pos_q;
    logic [CW-1:0] last_idx;

    always_comb begin
        last_idx = e1_sel ? CW'(E1_WIN - 1) : CW'(T1_WIN - 1);
        win_end  = bit_en && (pos_q >= last_idx);
        pos_d    = pos_q;
        if (bit_en) begin
            pos_d = win_end ? '0 : pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

endmodule

// File: rtl/ais_zero_acc.sv
module ais_zero_acc #(
    parameter int ZERO_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    input  logic win_end,
    output logic quiet
);
    localparam int ZW  = $clog2(ZERO_LIMIT + 2);
    localparam int SAT = ZERO_LIMIT + 1;

    logic [ZW-1:0] zc_d, zc_q;
    logic [ZW-1:0] total;

    always_comb begin
        total = zc_q;
        if (!bit_in && (zc_q != ZW'(SAT))) begin
            total = zc_q + 1'b1;
        end
        quiet = (total <= ZW'(ZERO_LIMIT));
        zc_d  = zc_q;
        if (bit_en) begin
            zc_d = win_end ? '0 : total;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) zc_q <= '0;
        else        zc_q <= zc_d;
    end

endmodule

// File: rtl/ais_rule_eval.sv
module ais_rule_eval
    import ais_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ais_rule_e rule,
    input  logic      win_end,
    input  logic      quiet,
    input  logic      lof,
    input  logic      frame_found,
    output logic      ais
);
    rule_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (win_end) begin
            unique case (rule)
                RULE_T1: begin
                    if (quiet && st_q.prev_quiet && lof) st_d.ais = 1'b1;
                    else if (!quiet)                     st_d.ais = 1'b0;
                end
                RULE_E1_SINGLE: begin
                    if (quiet && lof) st_d.ais = 1'b1;
                    else if (!quiet)  st_d.ais = 1'b0;
                end
                RULE_E1_PAIR: begin
                    if (quiet && st_q.prev_quiet)        st_d.ais = 1'b1;
                    else if (!quiet && st_q.prev_noisy)  st_d.ais = 1'b0;
                end
                default: st_d.ais = st_q.ais;
            endcase
            st_d.prev_quiet = quiet;
            st_d.prev_noisy = !quiet;
        end
        if ((rule == RULE_E1_PAIR) && frame_found) begin
            st_d.ais = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ais = st_q.ais;

endmodule

// File: rtl/ais_detector.sv
module ais_detector
    import ais_pkg::*;
#(
    parameter int T1_WIN     = 386,
    parameter int E1_WIN     = 512,
    parameter int ZERO_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_en,
    input  logic lof,
    input  logic frame_found,
    input  logic std_sel,
    input  logic e1_rule,
    output logic ais
);
    ais_rule_e rule;
    logic      win_end;
    logic      quiet;
    logic      pair_mode;

    always_comb begin
        if (!std_sel)     rule = RULE_T1;
        else if (e1_rule) rule = RULE_E1_PAIR;
        else              rule = RULE_E1_SINGLE;
    end

    assign pair_mode = (rule == RULE_E1_PAIR);

    ais_win_ctr #(.T1_WIN(T1_WIN), .E1_WIN(E1_WIN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .e1_sel  (std_sel),
        .win_end (win_end)
    );

    ais_zero_acc #(.ZERO_LIMIT(ZERO_LIMIT)) u_zero (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .win_end (win_end),
        .quiet   (quiet)
    );

    ais_rule_eval u_rule (
        .clk         (clk),
        .rst_n       (rst_n),
        .rule        (rule),
        .win_end     (win_end),
        .quiet       (quiet),
        .lof         (lof),
        .frame_found (frame_found),
        .ais         (ais)
    );

endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic ais,
    input logic lof,
    input logic frame_found,
    input logic win_end,
    input logic quiet,
    input logic pair_mode
);
    // R10: outside window ends and paired-rule frame recovery the status holds
    p_hold_between_windows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_end && !(pair_mode && frame_found)) |=> $stable(ais));

    // R8: frame recovery in the paired E1 rule drops the alarm on the next cycle
    p_found_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode && frame_found) |=> !ais);

    // R11: a rise needs a quiet window closing
    p_rise_needs_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ais) |-> $past(win_end && quiet));

    // R4: outside the paired rule a rise needs loss of frame alignment
    p_rise_needs_lof_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ais) && $past(!pair_mode)) |-> $past(lof));

    // R9: outside the paired rule a fall needs a noisy window closing
    p_fall_needs_noisy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ais) && $past(!pair_mode)) |-> $past(win_end && !quiet));

endmodule

bind ais_detector ais_detector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ais         (ais),
    .lof         (lof),
    .frame_found (frame_found),
    .win_end     (win_end),
    .quiet       (quiet),
    .pair_mode   (pair_mode)
);

// File: tb/ais_detector_tb.sv
module ais_detector_tb;
    localparam int T1W = 12;
    localparam int E1W = 16;
    localparam int LIM = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b1, bit_en = 1'b0, lof = 1'b0, frame_found = 1'b0;
    logic std_sel = 1'b0, e1_rule = 1'b0;
    logic ais;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state, built from the requirements
    int   m_pos, m_zc;
    logic m_ais, m_pq, m_pn;

    always #2.5 clk = ~clk;

    ais_detector #(.T1_WIN(T1W), .E1_WIN(E1W), .ZERO_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_en(bit_en), .lof(lof),
        .frame_found(frame_found), .std_sel(std_sel), .e1_rule(e1_rule), .ais(ais)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ais=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model(input logic b, input logic en, input logic l, input logic f);
        int   len;
        int   z;
        logic q;
        logic pair;
        len  = std_sel ? E1W : T1W;
        pair = std_sel && e1_rule;
        if (en) begin
            z = m_zc + (b ? 0 : 1);
            if (z > LIM + 1) z = LIM + 1;
            if (m_pos == len - 1) begin
                q = (z <= LIM);
                if (!std_sel) begin
                    if (q && m_pq && l) m_ais = 1'b1; else if (!q) m_ais = 1'b0;
                end else if (!e1_rule) begin
                    if (q && l) m_ais = 1'b1; else if (!q) m_ais = 1'b0;
                end else begin
                    if (q && m_pq) m_ais = 1'b1; else if (!q && m_pn) m_ais = 1'b0;
                end
                m_pq = q; m_pn = !q; m_pos = 0; m_zc = 0;
            end else begin
                m_pos++; m_zc = z;
            end
        end
        if (pair && f) m_ais = 1'b0;
    endtask

    task automatic step(input logic b, input logic en, input logic l, input logic f,
                        input string tag);
        bit_in = b; bit_en = en; lof = l; frame_found = f;
        model(b, en, l, f);
        @(posedge clk); #1;
        check(ais, m_ais, tag);
    endtask

    task automatic do_reset(input logic s, input logic r);
        rst_n = 1'b0; bit_en = 1'b0; frame_found = 1'b0; lof = 1'b0; bit_in = 1'b1;
        std_sel = s; e1_rule = r;
        repeat (2) @(posedge clk);
        #1;
        check(ais, 1'b0, "R1");
        m_pos = 0; m_zc = 0; m_ais = 1'b0; m_pq = 1'b0; m_pn = 1'b0;
        rst_n = 1'b1;
    endtask

    // one window with nz zeros at its start
    task automatic feed(input int nz, input logic l, input string tag);
        int len;
        len = std_sel ? E1W : T1W;
        for (int i = 0; i < len; i++) step((i < nz) ? 1'b0 : 1'b1, 1'b1, l, 1'b0, tag);
    endtask

    task automatic rand_run(input int n, input logic s, input logic r, input string tag);
        logic l;
        do_reset(s, r);
        l = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (($urandom % 40) == 0) l = ~l;
            step(($urandom % 100) >= 7, ($urandom % 4) != 0, l,
                 ($urandom % 150) == 0, tag);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // T1 rule
        do_reset(1'b0, 1'b0);
        feed(0, 1'b1, "R3");       check(ais, 1'b0, "R3 single window");
        feed(2, 1'b1, "R11");      check(ais, 1'b1, "R3 R11 two quiet windows");
        feed(3, 1'b1, "R9");       check(ais, 1'b0, "R9 R11 three zeros clear");
        do_reset(1'b0, 1'b0);
        feed(0, 1'b0, "R4"); feed(0, 1'b0, "R4");
        check(ais, 1'b0, "R4 no lof");

        // E1 single rule
        do_reset(1'b1, 1'b0);
        feed(1, 1'b1, "R5");       check(ais, 1'b1, "R5 one quiet window");
        for (int i = 0; i < E1W; i++) begin
            step(1'b0, 1'b0, 1'b1, 1'b0, "R2");
            step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
        end
        check(ais, 1'b1, "R2 stalled zeros ignored");
        feed(3, 1'b1, "R9");       check(ais, 1'b0, "R9 E1 single clear");

        // E1 paired rule
        do_reset(1'b1, 1'b1);
        feed(0, 1'b0, "R6");       check(ais, 1'b0, "R6 first window");
        feed(2, 1'b0, "R6");       check(ais, 1'b1, "R6 pair without lof");
        for (int i = 0; i < E1W - 1; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R10");
        check(ais, 1'b1, "R10 mid-window hold");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R7");
        check(ais, 1'b1, "R7 one noisy window");
        feed(5, 1'b0, "R7");       check(ais, 1'b0, "R7 two noisy windows");
        feed(0, 1'b0, "R6"); feed(0, 1'b0, "R6");
        check(ais, 1'b1, "R6 re-declare");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R8");
        check(ais, 1'b0, "R8 frame found");
        feed(0, 1'b0, "R6");
        for (int i = 0; i < E1W - 1; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R8");
        check(ais, 1'b0, "R8 overrides closing window");

        rand_run(4000, 1'b0, 1'b0, "R3 R4 R9 random T1");
        rand_run(4000, 1'b1, 1'b0, "R5 R9 R2 random E1 single");
        rand_run(4000, 1'b1, 1'b1, "R6 R7 R8 R10 random E1 pair");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule